// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block produces the strobe timing for register and PIO data accesses on a parallel ATA bus shared by two devices. It keeps two timing words. The shared word holds a merged timing that is safe for both devices. The fast word is used only for the one device that a control bit marks as fast. When a request is accepted, the block takes the word that fits the addressed device. It then steps through address setup, the read or write strobe, and recovery. It drives the write-data enable for the hold time and pulses `done` when the cycle is over.

During the strobe the device can stretch the cycle by holding IORDY low. The block bounds that stretch with a programmable timeout window. If the window runs out while IORDY is still low, the cycle is forced to end and a sticky flag is raised. Each programmed phase count gets a fixed number of extra cycles from the hardware. Software therefore writes values reduced by that amount.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset both timing words hold setup 6, active 19, recovery 15 and hold 2. The fast device is device 0, the timeout field is 11 (an 89-cycle window), and the timeout flag is clear.
- R2: A write to `cfg_addr` 0 loads the shared word and a write to `cfg_addr` 1 loads the fast word. The fields are setup in bits 30:27, active in bits 25:20, recovery in bits 18:13 and write hold in bits 11:9.
- R3: An accepted access spends setup+2 cycles with `busy` high and both strobes high. It then drives its strobe low for at least active+1 cycles and spends recovery+1 cycles with both strobes high.
- R4: Bit 28 of a write to `cfg_addr` 2 names the fast device. An access whose `req_dev` equals it uses the fast word, and any other access uses the shared word. The choice and the word's values are captured when the request is accepted.
- R5: Once the minimum active length is met, the strobe stays low while IORDY is sampled low. It rises after the first clock edge that samples IORDY high.
- R6: Bits 31:23 of a write to `cfg_addr` 3 set RDYT, giving a window of 8*RDYT+1 active cycles. If IORDY is still low at the edge that closes both the window and the minimum active length, the strobe ends and `tmo_flag` sets. If IORDY is high at that edge, the cycle ends normally and the flag stays clear.
- R7: `tmo_flag` stays set until a write to `cfg_addr` 2 with bit 31 set clears it. If a timeout occurs at the same edge as that write, the flag ends up set.
- R8: Reads drive only `ata_dior_n` low and writes drive only `ata_diow_n` low. For a write, `ata_dd_oe` is high through setup and active and for the first min(hold, recovery+1) recovery cycles. It stays low for reads.
- R9: `done` is a one-cycle pulse in the cycle after the last recovery cycle, with `busy` low. A request seen while `busy` is high is ignored. A request seen in an idle cycle, including the `done` cycle, is accepted and raises `busy` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 shared word, 1 fast word, 2 control, 3 timeout |
| cfg_wdata | input | 32 | Configuration write data |
| req | input | 1 | Access request |
| req_dev | input | 1 | Device addressed by the request |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| ata_iordy | input | 1 | Device ready; low stretches the active phase |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse when an access completes |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_oe | output | 1 | Write-data drive enable |
| tmo_flag | output | 1 | Sticky IORDY timeout flag |

## Verification
There are two cases where two functions meet in the same cycle. In the first, IORDY rises in the very cycle in which the timeout window closes. The bench arranges this by releasing IORDY exactly after 8*RDYT+1 active cycles. It expects a normal end with the flag clear. In the second, a flag-clearing control write lands on the same edge as a timeout. The bench expects the flag to be set afterwards. A cycle-by-cycle reference model is compared on every clock, so the exact cycle of each outcome is judged as well as its final state. A request held across `done` checks that acceptance and completion can share a cycle.

// File: rtl/ata_pio_timer.sv
module ata_pio_timer #(
  parameter int RDYT_W   = 9,
  parameter int RDYT_LSB = 23,
  parameter int RDYT_RST = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        req,
  input  logic        req_dev,
  input  logic        req_write,
  input  logic        ata_iordy,
  output logic        busy,
  output logic        done,
  output logic        ata_dior_n,
  output logic        ata_diow_n,
  output logic        ata_dd_oe,
  output logic        tmo_flag
);
  localparam int CW = RDYT_W + 4;
  localparam int TW = 19;
  localparam logic [TW-1:0] DEF_TW = {4'd6, 6'd19, 6'd15, 3'd2};

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_REC} st_t;

  st_t              st;
  logic [TW-1:0]    shared_tw, fast_tw, pick;
  logic             fast_dev, wr_q;
  logic [RDYT_W-1:0] rdyt;
  logic [3:0]       t_set;
  logic [5:0]       t_act, t_rec;
  logic [2:0]       t_hold;
  logic [CW-1:0]    cnt, tmo_lim;
  logic [TW-1:0]    wfield;
  logic             set_end, act_min, act_ok, act_to, rec_end, clr;
  logic             unused_bits;

  assign wfield      = {cfg_wdata[30:27], cfg_wdata[25:20], cfg_wdata[18:13], cfg_wdata[11:9]};
  assign unused_bits = ^{cfg_wdata[26], cfg_wdata[19], cfg_wdata[12], cfg_wdata[8:0]};
  assign pick        = (req_dev == fast_dev) ? fast_tw : shared_tw;
  assign tmo_lim     = CW'({rdyt, 3'b000}) + CW'(1);
  assign set_end     = cnt == CW'(t_set) + CW'(1);
  assign act_min     = cnt >= CW'(t_act);
  assign act_ok      = act_min && ata_iordy;
  assign act_to      = act_min && !ata_iordy && (cnt + CW'(1) >= tmo_lim);
  assign rec_end     = cnt == CW'(t_rec);
  assign clr         = cfg_we && cfg_addr == 2'd2 && cfg_wdata[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      shared_tw <= DEF_TW;
      fast_tw   <= DEF_TW;
      fast_dev  <= 1'b0;
      rdyt      <= RDYT_W'(RDYT_RST);
      t_set     <= '0;
      t_act     <= '0;
      t_rec     <= '0;
      t_hold    <= '0;
      wr_q      <= 1'b0;
      cnt       <= '0;
      done      <= 1'b0;
      tmo_flag  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    shared_tw <= wfield;
          2'd1:    fast_tw   <= wfield;
          2'd2:    fast_dev  <= cfg_wdata[28];
          default: rdyt      <= cfg_wdata[RDYT_LSB +: RDYT_W];
        endcase
      end
      if (clr) tmo_flag <= 1'b0;
      case (st)
        S_IDLE:
          if (req) begin
            st     <= S_SETUP;
            cnt    <= '0;
            {t_set, t_act, t_rec, t_hold} <= pick;
            wr_q   <= req_write;
          end
        S_SETUP:
          if (set_end) begin
            st  <= S_ACT;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
        S_ACT:
          if (act_ok || act_to) begin
            st  <= S_REC;
            cnt <= '0;
            if (act_to) tmo_flag <= 1'b1;
          end else cnt <= cnt + CW'(1);
        default:
          if (rec_end) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt + CW'(1);
      endcase
    end
  end

  assign busy       = st != S_IDLE;
  assign ata_dior_n = !(st == S_ACT && !wr_q);
  assign ata_diow_n = !(st == S_ACT && wr_q);
  assign ata_dd_oe  = wr_q && (st == S_SETUP || st == S_ACT ||
                               (st == S_REC && cnt < CW'(t_hold)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  // R6
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> ($past(!ata_iordy) && $past(busy)));
  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !clr) |=> tmo_flag);
  // R3
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ata_dior_n) || $fell(ata_diow_n)) |-> $past(busy));
endmodule

// File: tb/sim_ata_pio_timer.sv
module sim_ata_pio_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, req = 1'b0, req_dev = 1'b0, req_write = 1'b0, ata_iordy = 1'b1;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic busy, done, ata_dior_n, ata_diow_n, ata_dd_oe, tmo_flag;
  integer n_chk = 0, n_fail = 0;
  logic cur_fast = 1'b0;

  always #2 clk = ~clk;

  ata_pio_timer u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req(req), .req_dev(req_dev), .req_write(req_write),
    .ata_iordy(ata_iordy), .busy(busy), .done(done), .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n), .ata_dd_oe(ata_dd_oe), .tmo_flag(tmo_flag));

  task automatic chk(input string tag, input integer got, input integer exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic [31:0] tw(input integer s, input integer a, input integer r, input integer h);
    tw = (32'(s) << 27) | (32'(a) << 20) | (32'(r) << 13) | (32'(h) << 9);
  endfunction

  // reference model
  integer m_ph, m_left, m_el, m_hk, m_tlim;
  integer sh[4], fa[4], cu[4];
  logic m_fast, m_wr, m_done, m_tmo, ev_to;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_el = 0; m_hk = 0; m_tlim = 89;
      sh = '{6, 19, 15, 2}; fa = '{6, 19, 15, 2}; cu = '{0, 0, 0, 0};
      m_fast = 0; m_wr = 0; m_done = 0; m_tmo = 0;
    end else begin
      ev_to = 0;
      m_done = 0;
      case (m_ph)
        0: if (req) begin
             cu = (req_dev == m_fast) ? fa : sh;
             m_wr = req_write; m_ph = 1; m_left = cu[0] + 2;
           end
        1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_el = 0; end end
        2: begin
             m_el++;
             if (m_el >= cu[1] + 1 && ata_iordy) begin m_ph = 3; m_left = cu[2] + 1; m_hk = 0; end
             else if (m_el >= cu[1] + 1 && m_el >= m_tlim) begin
               ev_to = 1; m_ph = 3; m_left = cu[2] + 1; m_hk = 0;
             end
           end
        default: begin m_hk++; m_left--; if (m_left == 0) begin m_ph = 0; m_done = 1; end end
      endcase
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: sh = '{int'(cfg_wdata[30:27]), int'(cfg_wdata[25:20]), int'(cfg_wdata[18:13]), int'(cfg_wdata[11:9])};
          2'd1: fa = '{int'(cfg_wdata[30:27]), int'(cfg_wdata[25:20]), int'(cfg_wdata[18:13]), int'(cfg_wdata[11:9])};
          2'd2: begin m_fast = cfg_wdata[28]; if (cfg_wdata[31]) m_tmo = 0; end
          default: m_tlim = 8 * int'(cfg_wdata[31:23]) + 1;
        endcase
      end
      if (ev_to) m_tmo = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 busy", busy, m_ph != 0);
      chk("R9 done", done, m_done);
      chk("R3 dior_n", ata_dior_n, !(m_ph == 2 && !m_wr));
      chk("R8 diow_n", ata_diow_n, !(m_ph == 2 && m_wr));
      chk("R8 dd_oe", ata_dd_oe, m_wr && (m_ph == 1 || m_ph == 2 || (m_ph == 3 && m_hk < cu[3])));
      chk("R6 tmo_flag", tmo_flag, m_tmo);
    end
  end

  task automatic wr_cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic access(input logic dev, input logic wr, input integer low_n, input integer clr_k,
                        output integer s, output integer a, output integer r, output integer ho);
    @(negedge clk); req = 1; req_dev = dev; req_write = wr; ata_iordy = (low_n == 0);
    @(negedge clk); req = 0;
    s = 0; a = 0; r = 0; ho = 0;
    while (busy && ata_dior_n && ata_diow_n) begin s++; @(negedge clk); end
    while (!ata_dior_n || !ata_diow_n) begin
      cfg_we = 0; a++;
      if (a >= low_n) ata_iordy = 1;
      if (a == clr_k) begin cfg_we = 1; cfg_addr = 2'd2; cfg_wdata = {1'b1, 2'b00, cur_fast, 28'd0}; end
      @(negedge clk);
    end
    cfg_we = 0;
    while (busy) begin r++; if (ata_dd_oe) ho++; @(negedge clk); end
    chk("R9 done after recovery", done, 1);
    ata_iordy = 1;
  endtask

  function automatic integer exp_act(input integer amin, input integer tl, input integer l);
    integer m;
    m = (amin > tl) ? amin : tl;
    if (l <= amin) exp_act = amin;
    else if (m < l) exp_act = m;
    else exp_act = l;
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    integer s, a, r, ho;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle busy", busy, 0);
    chk("R1 flag clear", tmo_flag, 0);

    access(0, 0, 0, -1, s, a, r, ho);
    chk("R1 default setup", s, 8); chk("R1 default active", a, 20); chk("R3 default recovery", r, 16);

    wr_cfg(0, tw(1, 3, 2, 5));
    wr_cfg(1, tw(0, 1, 4, 1));
    cur_fast = 1; wr_cfg(2, 32'h1000_0000);
    access(1, 1, 0, -1, s, a, r, ho);
    chk("R4 fast setup", s, 2); chk("R4 fast active", a, 2); chk("R2 fast recovery", r, 5);
    chk("R8 hold short", ho, 1);
    access(0, 1, 0, -1, s, a, r, ho);
    chk("R4 shared setup", s, 3); chk("R4 shared active", a, 4); chk("R2 shared recovery", r, 3);
    chk("R8 hold clipped", ho, 3);
    access(0, 0, 0, -1, s, a, r, ho);
    chk("R8 read no oe", ho, 0);
    cur_fast = 0; wr_cfg(2, 32'h0000_0000);
    access(0, 0, 0, -1, s, a, r, ho);
    chk("R4 fast moved", s, 2);

    wr_cfg(3, 32'(20) << 23);
    access(1, 0, 10, -1, s, a, r, ho);
    chk("R5 stretch", a, exp_act(4, 161, 10)); chk("R5 no flag", tmo_flag, 0);

    wr_cfg(3, 32'(1) << 23);
    access(1, 0, 30, -1, s, a, r, ho);
    chk("R6 timeout len", a, exp_act(4, 9, 30)); chk("R6 flag set", tmo_flag, 1);
    wr_cfg(2, {1'b1, 2'b00, cur_fast, 28'd0});
    chk("R7 cleared", tmo_flag, 0);

    access(1, 1, 9, -1, s, a, r, ho);
    chk("R6 same cycle release", a, 9); chk("R6 no flag on release", tmo_flag, 0);

    access(1, 0, 30, 9, s, a, r, ho);
    chk("R7 set wins", tmo_flag, 1);
    wr_cfg(2, {1'b1, 2'b00, cur_fast, 28'd0});

    wr_cfg(0, tw(2, 20, 3, 0));
    access(1, 0, 40, -1, s, a, r, ho);
    chk("R6 minimum beyond window", a, 21); chk("R6 flag long min", tmo_flag, 1);
    wr_cfg(2, {1'b1, 2'b00, cur_fast, 28'd0});

    @(negedge clk); req = 1; req_dev = 0; req_write = 0;
    @(negedge clk);
    while (!done) @(negedge clk);
    chk("R9 done idle", busy, 0);
    @(negedge clk);
    chk("R9 back to back", busy, 1);
    req = 0;
    while (busy) @(negedge clk);

    @(negedge clk); req = 1; req_dev = 1;
    @(negedge clk); req = 0;
    repeat (3) @(negedge clk);
    req = 1;
    @(negedge clk); req = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R9 busy request ignored", busy, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule